// File: doc/BRIEF.md
# Thirteen-Note Divider Bank with Per-Note Pulse Width

This block derives thirteen rectangular note outputs from a single master clock. Each note has a free-running counter with its own terminal count, so each output runs at its own division of the master clock. The default terminal counts follow equal-tempered semitone steps. Each note also holds its own 8-bit width value. That value sets how many master-clock cycles of every period the output stays high. Because each note has its own width, a duty cycle can be chosen per note even though the periods differ.

A small host writes the width values through one of two paths. The parallel path has an 8-bit data bus, a 4-bit channel address and a latch strobe, and it updates one note per strobe. The serial path has a clock, a data line and a load strobe. It shifts all thirteen width values in as a single 104-bit stream and then commits every one of them at once.

Every write is clamped to a legal range and parked in a pending register. It reaches the compare logic only when that note's counter wraps, so an output never shows a cut-short or stretched pulse.

Top module: `note_divider_bank`

## Requirements
- R1: Output `note_out[i]` is periodic with a period of TC_i+1 master-clock cycles. The default TC values for channels 0 to 12 are 239, 225, 213, 201, 190, 179, 169, 159, 150, 142, 134, 127 and 119.
- R2: Within each period, the output is high for exactly W cycles in one contiguous run that starts at the counter wrap, and low for the rest. W is the channel's active width.
- R3: A written width value v becomes max(1, min(v, TC_i-1)). A write of 0 gives 1 and a write of 255 gives TC_i-1, so no output is ever stuck high or stuck low.
- R4: While `rst_n` is low at a clock edge, every counter goes to 0 and every width goes to floor(TC_i/2). All outputs read high during reset and in the first cycle after it.
- R5: A rising edge on `par_latch` writes `par_data` to the channel numbered by `par_addr`, where addresses 0 to 12 select channels 0 to 12.
- R6: A parallel write to address 13, 14 or 15 changes no channel's width.
- R7: On each rising edge of `ser_clk`, `ser_data` is shifted in. The stream is 104 bits long, channel 0 comes first and each byte is sent MSB first. A rising edge on `ser_load` writes the last 104 bits shifted in to all thirteen channels. Shifting without a load changes no width.
- R8: A new width takes effect at the next wrap of that channel's counter. The high run in progress when the write lands keeps the old width.
- R9: A parallel write and a serial load that arrive in the same cycle both take effect, and the parallel value wins for the channel it addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| par_data | input | 8 | Parallel width value |
| par_addr | input | 4 | Parallel channel select |
| par_latch | input | 1 | Parallel write strobe; the rising edge writes |
| ser_clk | input | 1 | Serial shift clock; data is taken on the rising edge |
| ser_data | input | 1 | Serial data bit |
| ser_load | input | 1 | Serial commit strobe; the rising edge loads all channels |
| note_out | output | 13 | Rectangular note outputs, bit i is channel i |

## Verification
The host-side strobes and the serial clock are taken to be slow compared with the master clock. Each of their levels is taken to last at least three master cycles, because they pass through two-stage synchronizers before their edges are detected. The parallel address and data lines are not synchronized, so the assertions assume these lines are stable from before the latch rises until after its synchronized edge. The serial data line is likewise assumed to settle before each serial clock rise. The stimulus changes the address, data and serial-data lines three master cycles ahead of any strobe edge and holds each strobe level for four master cycles. The random widths are chosen to favour 0 and 255 so that the clamp limits come up often.

// File: rtl/note_bank_pkg.sv
// Package note_bank_pkg
// Shared sizing for the note divider bank, and the default terminal counts.
// Assumes every terminal count lies in 3..2**NB_WBITS-1.
package note_bank_pkg;
    localparam int NB_CHANNELS = 13;
    localparam int NB_WBITS    = 8;
    localparam int NB_ABITS    = 4;
    localparam int NB_SYNC     = 2;
    // Channel 0 sits in the least significant byte.
    localparam logic [NB_CHANNELS*NB_WBITS-1:0] NB_DEFAULT_TC = {
        8'd119, 8'd127, 8'd134, 8'd142, 8'd150, 8'd159, 8'd169,
        8'd179, 8'd190, 8'd201, 8'd213, 8'd225, 8'd239
    };
endpackage

// File: rtl/nb_sync.sv
// Module nb_sync
// A multi-stage synchronizer for one slow asynchronous host line.
// Assumes STAGES >= 2 and that the line holds each level for longer than STAGES clocks.
module nb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level
);
    logic [STAGES-1:0] pipe;

    // Purpose: move the input through the flop chain into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[STAGES-2:0], async_in};
        end
    end

    assign level = pipe[STAGES-1];
endmodule

// File: rtl/nb_serial_loader.sv
// Module nb_serial_loader
// Shifts synchronized serial data in on each rising edge of the shift clock,
// and gives a one-cycle commit pulse on a rising edge of the load strobe.
// The first bit shifted in ends up in the most significant position of the image.
// Assumes the inputs are already synchronized levels.
module nb_serial_loader #(
    parameter int NUM_CH = 13,
    parameter int W_BITS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sclk_lvl,
    input  logic                       sdat_lvl,
    input  logic                       sload_lvl,
    output logic                       commit,
    output logic [NUM_CH*W_BITS-1:0]   image
);
    localparam int TOTAL = NUM_CH * W_BITS;

    logic             sclk_q;
    logic             sload_q;
    logic             shift_en;
    logic [TOTAL-1:0] sr;

    assign shift_en = sclk_lvl & ~sclk_q;
    assign commit   = sload_lvl & ~sload_q;
    assign image    = sr;

    // Purpose: keep the previous strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            sload_q <= 1'b0;
        end else begin
            sclk_q  <= sclk_lvl;
            sload_q <= sload_lvl;
        end
    end

    // Purpose: shift one bit in at the LSB end on each shift-clock rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (shift_en) begin
            sr <= {sr[TOTAL-2:0], sdat_lvl};
        end
    end

    // R7: a shift takes the new bit at the bottom and moves every other bit up one place.
    a_r7_shift_order: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (sr[0] == $past(sdat_lvl)) && (sr[TOTAL-1:1] == $past(sr[TOTAL-2:0])));
    // R7: a commit pulse lasts a single cycle.
    a_r7_commit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);
endmodule

// File: rtl/nb_parallel_loader.sv
// Module nb_parallel_loader
// Turns a synchronized latch strobe into a registered one-hot channel write.
// Addresses at or above NUM_CH produce no write.
// Assumes addr and data are stable around the synchronized strobe edge.
module nb_parallel_loader #(
    parameter int NUM_CH    = 13,
    parameter int W_BITS    = 8,
    parameter int ADDR_BITS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 latch_lvl,
    input  logic [ADDR_BITS-1:0] addr,
    input  logic [W_BITS-1:0]    data,
    output logic [NUM_CH-1:0]    wr_en,
    output logic [W_BITS-1:0]    wr_data
);
    logic latch_q;
    logic strobe;

    assign strobe = latch_lvl & ~latch_q;

    // Purpose: keep the previous latch level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= 1'b0;
        end else begin
            latch_q <= latch_lvl;
        end
    end

    // Purpose: decode the address into a one-cycle write enable and capture the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= '0;
            wr_data <= '0;
        end else begin
            for (int k = 0; k < NUM_CH; k++) begin
                wr_en[k] <= strobe && (int'(addr) == k);
            end
            if (strobe) begin
                wr_data <= data;
            end
        end
    end

    // R5: at most one channel is written per cycle.
    a_r5_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en));
    // R6: an out-of-range address yields no write enable.
    a_r6_high_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && int'(addr) >= NUM_CH) |=> (wr_en == '0));
    // R5: a write enable always follows a strobe edge.
    a_r5_enable_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en != '0) |-> $past(strobe));
endmodule

// File: rtl/nb_channel.sv
// Module nb_channel
// One note: a wrap-around counter from 0 to TC, a clamped pending width,
// and an active width that takes the pending value only at the wrap.
// The output is high while count < active width.
// Assumes 3 <= TC < 2**W_BITS.
module nb_channel #(
    parameter int W_BITS = 8,
    parameter int TC     = 239
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [W_BITS-1:0] wr_val,
    output logic              note
);
    localparam logic [W_BITS-1:0] TOP_W = W_BITS'(TC);
    localparam logic [W_BITS-1:0] LO_W  = W_BITS'(1);
    localparam logic [W_BITS-1:0] HI_W  = W_BITS'(TC - 1);
    localparam logic [W_BITS-1:0] MID_W = W_BITS'(TC / 2);

    logic [W_BITS-1:0] cnt;
    logic [W_BITS-1:0] pend;
    logic [W_BITS-1:0] act;
    logic [W_BITS-1:0] clamped;
    logic              wrap;

    assign wrap = (cnt == TOP_W);

    // Purpose: limit an incoming width to the range 1..TC-1.
    always_comb begin
        if (wr_val < LO_W) begin
            clamped = LO_W;
        end else if (wr_val > HI_W) begin
            clamped = HI_W;
        end else begin
            clamped = wr_val;
        end
    end

    // Purpose: advance the note counter and wrap after TC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Purpose: hold the most recent clamped write until the next wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= MID_W;
        end else if (wr_en) begin
            pend <= clamped;
        end
    end

    // Purpose: move the pending width into the active width at the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act <= MID_W;
        end else if (wrap) begin
            act <= pend;
        end
    end

    assign note = (cnt < act);

    // R1: the counter never passes its terminal count.
    a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TOP_W);
    // R3: the active and pending widths stay inside the legal range.
    a_r3_width_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (act >= LO_W) && (act <= HI_W) && (pend >= LO_W) && (pend <= HI_W));
    // R8: the active width changes only right after a wrap.
    a_r8_update_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act) |-> (cnt == '0));
    // R2: a high run starts only at the start of a period.
    a_r2_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(note) |-> (cnt == '0));
    // R2: the output is high at the start of every period.
    a_r2_high_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> note);
endmodule

// File: rtl/note_divider_bank.sv
// Module note_divider_bank
// Top of the note divider bank. It synchronizes the host lines, merges the
// parallel and serial writes (the parallel value wins for the channel it
// addresses), and instantiates one channel per note.
// Assumes host strobes are slow compared with clk.
module note_divider_bank
    import note_bank_pkg::*;
#(
    parameter int NUM_CH    = NB_CHANNELS,
    parameter int W_BITS    = NB_WBITS,
    parameter int ADDR_BITS = NB_ABITS,
    parameter int SYNC_STG  = NB_SYNC,
    parameter logic [NUM_CH*W_BITS-1:0] TERM_COUNTS = NB_DEFAULT_TC
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [W_BITS-1:0]    par_data,
    input  logic [ADDR_BITS-1:0] par_addr,
    input  logic                 par_latch,
    input  logic                 ser_clk,
    input  logic                 ser_data,
    input  logic                 ser_load,
    output logic [NUM_CH-1:0]    note_out
);
    localparam int TOTAL = NUM_CH * W_BITS;

    logic                latch_lvl;
    logic                sclk_lvl;
    logic                sdat_lvl;
    logic                sload_lvl;
    logic                ser_commit;
    logic [TOTAL-1:0]    ser_image;
    logic [NUM_CH-1:0]   par_wr;
    logic [W_BITS-1:0]   par_val;

    nb_sync #(.STAGES(SYNC_STG)) u_sync_latch (
        .clk(clk), .rst_n(rst_n), .async_in(par_latch), .level(latch_lvl));
    nb_sync #(.STAGES(SYNC_STG)) u_sync_sclk (
        .clk(clk), .rst_n(rst_n), .async_in(ser_clk), .level(sclk_lvl));
    nb_sync #(.STAGES(SYNC_STG)) u_sync_sdat (
        .clk(clk), .rst_n(rst_n), .async_in(ser_data), .level(sdat_lvl));
    nb_sync #(.STAGES(SYNC_STG)) u_sync_sload (
        .clk(clk), .rst_n(rst_n), .async_in(ser_load), .level(sload_lvl));

    nb_serial_loader #(.NUM_CH(NUM_CH), .W_BITS(W_BITS)) u_serial (
        .clk(clk), .rst_n(rst_n),
        .sclk_lvl(sclk_lvl), .sdat_lvl(sdat_lvl), .sload_lvl(sload_lvl),
        .commit(ser_commit), .image(ser_image));

    nb_parallel_loader #(.NUM_CH(NUM_CH), .W_BITS(W_BITS), .ADDR_BITS(ADDR_BITS)) u_parallel (
        .clk(clk), .rst_n(rst_n),
        .latch_lvl(latch_lvl), .addr(par_addr), .data(par_data),
        .wr_en(par_wr), .wr_data(par_val));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_note
        logic              ch_we;
        logic [W_BITS-1:0] ch_val;

        // Purpose: choose the write source for this channel; the parallel value wins (R9).
        always_comb begin
            ch_we  = par_wr[i] | ser_commit;
            ch_val = par_wr[i] ? par_val : ser_image[TOTAL-1-i*W_BITS -: W_BITS];
        end

        nb_channel #(
            .W_BITS(W_BITS),
            .TC(int'(TERM_COUNTS[i*W_BITS +: W_BITS]))
        ) u_ch (
            .clk(clk), .rst_n(rst_n),
            .wr_en(ch_we), .wr_val(ch_val),
            .note(note_out[i]));
    end
endmodule

// File: tb/note_divider_bank_test.sv
// Bench for note_divider_bank. It uses seeded random width writes and directed
// corner cases, and checks the outputs against a widths model kept in the bench.
module note_divider_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  par_data = '0;
    logic [3:0]  par_addr = '0;
    logic        par_latch = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic        ser_load = 1'b0;
    logic [12:0] note_out;

    int tc_tab [13] = '{239, 225, 213, 201, 190, 179, 169, 159, 150, 142, 134, 127, 119};
    int exp_w  [13];
    int ser_w  [13];
    logic [12:0] samp [0:511];
    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    note_divider_bank uut (
        .clk(clk), .rst_n(rst_n),
        .par_data(par_data), .par_addr(par_addr), .par_latch(par_latch),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
        .note_out(note_out));

    function automatic int clampw(input int v, input int tc);
        if (v < 1) return 1;
        if (v > tc - 1) return tc - 1;
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R5: one parallel write; a write to addresses 13..15 must be ignored (R6).
    task automatic par_write(input int addr, input int data);
        @(negedge clk);
        par_addr = 4'(addr);
        par_data = 8'(data);
        repeat (3) @(negedge clk);
        par_latch = 1'b1;
        repeat (4) @(negedge clk);
        par_latch = 1'b0;
        repeat (4) @(negedge clk);
        if (addr < 13) exp_w[addr] = clampw(data, tc_tab[addr]);
    endtask

    // R7: shift ser_w out with channel 0 first and MSB first; load it if asked.
    task automatic ser_send(input bit do_load);
        for (int ch = 0; ch < 13; ch++) begin
            for (int b = 7; b >= 0; b--) begin
                @(negedge clk);
                ser_data = 1'((ser_w[ch] >> b) & 1);
                repeat (3) @(negedge clk);
                ser_clk = 1'b1;
                repeat (4) @(negedge clk);
                ser_clk = 1'b0;
            end
        end
        if (do_load) begin
            repeat (4) @(negedge clk);
            ser_load = 1'b1;
            repeat (4) @(negedge clk);
            ser_load = 1'b0;
            for (int ch = 0; ch < 13; ch++) exp_w[ch] = clampw(ser_w[ch], tc_tab[ch]);
        end
        repeat (4) @(negedge clk);
    endtask

    // R1 R2: after settling, check the period, the high count and a single high run on every channel.
    task automatic measure(input string req);
        repeat (600) @(negedge clk);
        for (int t = 0; t < 480; t++) begin
            @(negedge clk);
            samp[t] = note_out;
        end
        for (int ch = 0; ch < 13; ch++) begin
            int p = tc_tab[ch] + 1;
            int hi = 0;
            int edges = 0;
            bit per_ok = 1'b1;
            for (int t = 0; t < p; t++) begin
                hi += int'(samp[t][ch]);
                if (samp[t][ch] != samp[t+p][ch]) per_ok = 1'b0;
                if (samp[t][ch] != samp[t+1][ch]) edges++;
            end
            check(per_ok && edges == 2 && hi == exp_w[ch],
                  $sformatf("%s ch%0d high cycles (period ok=%0d edges=%0d)", req, ch, per_ok, edges),
                  hi, exp_w[ch]);
        end
    endtask

    initial begin
        int run;
        void'($urandom(4242));
        for (int ch = 0; ch < 13; ch++) exp_w[ch] = tc_tab[ch] / 2;

        // R4: all outputs high during reset and in the first cycle after it.
        repeat (5) @(negedge clk);
        check(note_out == 13'h1FFF, "R4 outputs during reset", int'(note_out), 13'h1FFF);
        rst_n = 1'b1;
        @(negedge clk);
        check(note_out == 13'h1FFF, "R4 outputs after reset", int'(note_out), 13'h1FFF);
        measure("R4 R1 reset widths");

        // R3: the clamp limits and a plain value.
        par_write(0, 0);
        par_write(1, 255);
        par_write(12, 118);
        par_write(5, 7);
        measure("R3 R5 clamp and parallel write");

        // R6: addresses 13..15 are ignored.
        par_write(13, 3);
        par_write(14, 9);
        par_write(15, 250);
        measure("R6 high address ignored");

        // R7: shifting with no load changes nothing; then a full load.
        for (int ch = 0; ch < 13; ch++) ser_w[ch] = 10 + 7 * ch;
        ser_send(1'b0);
        measure("R7 shift without load");
        ser_send(1'b1);
        measure("R7 serial load");

        // R8: a write that lands mid-run keeps the old width until the wrap.
        par_write(0, 200);
        repeat (600) @(negedge clk);
        while (!note_out[0]) @(negedge clk);
        while (note_out[0]) @(negedge clk);
        while (!note_out[0]) @(negedge clk);
        run = 1;
        fork
            begin
                repeat (50) @(negedge clk);
                par_write(0, 20);
            end
            begin
                @(negedge clk);
                while (note_out[0]) begin
                    run++;
                    @(negedge clk);
                end
            end
        join
        check(run == 200, "R8 run in progress keeps old width", run, 200);
        while (!note_out[0]) @(negedge clk);
        run = 0;
        while (note_out[0]) begin
            run++;
            @(negedge clk);
        end
        check(run == 20, "R8 next run uses new width", run, 20);

        // R5 R6 R3: random parallel writes; widths 0 and 255 are favoured.
        for (int r = 0; r < 10; r++) begin
            int n = 1 + int'($urandom % 4);
            for (int k = 0; k < n; k++) begin
                int sel = int'($urandom % 4);
                int d = (sel == 0) ? 0 : (sel == 1) ? 255 : int'($urandom % 256);
                par_write(int'($urandom % 16), d);
            end
            measure("R5 R6 R3 random parallel");
        end

        // R7 R3: a random serial load.
        for (int ch = 0; ch < 13; ch++) ser_w[ch] = int'($urandom % 256);
        ser_w[3] = 0;
        ser_w[9] = 255;
        ser_send(1'b1);
        measure("R7 R3 random serial");

        // R9: a parallel write and a serial load in the same cycle; the parallel value wins.
        for (int ch = 0; ch < 13; ch++) ser_w[ch] = 30 + ch;
        ser_send(1'b0);
        @(negedge clk);
        par_addr = 4'd4;
        par_data = 8'd90;
        repeat (3) @(negedge clk);
        par_latch = 1'b1;
        ser_load = 1'b1;
        repeat (4) @(negedge clk);
        par_latch = 1'b0;
        ser_load = 1'b0;
        for (int ch = 0; ch < 13; ch++) exp_w[ch] = clampw(ser_w[ch], tc_tab[ch]);
        exp_w[4] = 90;
        measure("R9 simultaneous writes");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog (all requirements): actual %0d expected %0d", 150000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule